// File: doc/BRIEF.md
# Precharge-Fault Row-Corruption SRAM Model

This block is a cycle-level behavioural model of a small sprite-attribute SRAM whose rows are corrupted when the array's precharge is held off while the video-side scanner moves from one row to another. The array holds 2^ROW_AW rows of ROW_W bits. The scanner's row address does not change in a single jump. Each move is given as a sequence of single-bit flips, one per clock step, so every intermediate address reaches the array. The CPU side presents the upper byte of an address and read and write strobes. When that byte names the sprite page, precharge is disturbed.

If the CPU is off the page, precharge works and rows only change selection. If the CPU is on the page without reading, the bit lines keep the old row's data and write it into each newly selected row. If the CPU reads on the page, the word-line drivers are not precharged either. Every row visited during the transition stays enabled, and all of those rows merge to the data of the row where the accumulation began. Which rows are hit therefore depends on the order of the flips.

A preload port fills rows, a row-set input places the scanner without moving data, and a combinational read port exposes any row so that a testbench can compare the whole array after each transition.

Top module: `oam_precharge_fault`

## Requirements
- R1: After reset every row holds zero, `cur_row` is 0 and `wl_mask` is the one-hot mask of row 0.
- R2: Precharge is disturbed only when `cpu_addr_hi` equals PAGE (default 8'hFE). A read strobe with any other upper byte gives a normal transition.
- R3: A step with `step_valid` high inverts bit `step_bit` (0 to ROW_AW-1) of the selected row, and `cur_row` shows the new row after that clock edge.
- R4: A step without a page access moves the selection only. No row's contents change.
- R5: A step with a page access but no read strobe copies the current contents of the row selected before the step into the newly selected row.
- R6: A write strobe on the page has exactly the same effect as a bare page address (R5).
- R7: A step with a read strobe on the page adds the new row to the enabled set. Every row entered this way receives the data that the first row of the set held when accumulation began, so the rows that are hit depend on the flip order.
- R8: A read transition of a single flip involves exactly two rows. The earlier row's data is copied over the later row, and all other rows are untouched.
- R9: A step with `step_last` high ends the transition. The next read transition merges from its own starting row, not from earlier merged data.
- R10: `init_we` writes `init_data` into row `init_row`. `row_set` (without `step_valid`) selects `row_set_val` and moves no data.
- R11: `wl_mask` shows the enabled word lines: it grows by one row per non-final read step and is one-hot of `cur_row` at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_hi | input | PAGE_W | Upper byte of the CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| step_valid | input | 1 | One address-bit flip this cycle |
| step_bit | input | BIT_W | Index of the row-address bit that flips |
| step_last | input | 1 | This flip ends the transition |
| row_set | input | 1 | Place the scanner at `row_set_val` |
| row_set_val | input | ROW_AW | Row for `row_set` |
| init_we | input | 1 | Preload write enable |
| init_row | input | ROW_AW | Preload row |
| init_data | input | ROW_W | Preload data |
| rd_row | input | ROW_AW | Row to observe |
| rd_data | output | ROW_W | Contents of `rd_row` |
| cur_row | output | ROW_AW | Currently selected row |
| wl_mask | output | 2^ROW_AW | Enabled word lines |

## Verification
The same three-flip read transition from row 7 is run in opposite flip orders. Each order must hit a different set of rows, which separates order-aware accumulation from a plain end-to-end copy. Bare-address and write-strobe transitions run over the same reloaded pattern must give identical arrays. A mixed transition (off-page, then bare address, then read) checks that bit-line carry uses the current row while merging uses the captured start data. Off-page reads, a single-flip read, and back-to-back read transitions isolate the page decode, the two-row case and the end-of-transition reset of the merge source.

// File: rtl/oam_pf_pkg.sv
package oam_pf_pkg;
  // Precharge condition for one address step.
  typedef enum logic [1:0] {
    PC_NORMAL    = 2'd0,  // both precharges work
    PC_BL_HELD   = 2'd1,  // bit lines keep old data
    PC_BOTH_HELD = 2'd2   // bit lines and word-line drivers held
  } pc_mode_e;
endpackage

// File: rtl/oam_pf_precharge.sv
module oam_pf_precharge
  import oam_pf_pkg::*;
#(
  parameter int          PAGE_W = 8,
  parameter logic [PAGE_W-1:0] PAGE = 8'hFE
) (
  input  logic [PAGE_W-1:0] cpu_addr_hi,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic              page_hit,
  output pc_mode_e          mode
);
  always_comb begin
    page_hit = (cpu_addr_hi == PAGE);
    if (!page_hit)
      mode = PC_NORMAL;
    else if (cpu_rd && !cpu_wr)
      mode = PC_BOTH_HELD;
    else
      mode = PC_BL_HELD;
  end
endmodule

// File: rtl/oam_pf_wl_tracker.sv
module oam_pf_wl_tracker
  import oam_pf_pkg::*;
#(
  parameter int ROW_AW = 5,
  parameter int ROW_W  = 64,
  parameter int BIT_W  = 3,
  localparam int NROWS = 1 << ROW_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_valid,
  input  logic [BIT_W-1:0]  step_bit,
  input  logic              step_last,
  input  logic              row_set,
  input  logic [ROW_AW-1:0] row_set_val,
  input  pc_mode_e          mode,
  input  logic [ROW_W-1:0]  src_data,
  output logic [ROW_AW-1:0] cur_row,
  output logic [NROWS-1:0]  wl_mask,
  output logic              acc_active,
  output logic              wr_en,
  output logic [ROW_AW-1:0] wr_row,
  output logic [ROW_W-1:0]  wr_data
);
  function automatic logic [ROW_AW-1:0] flip_row(input logic [ROW_AW-1:0] r,
                                                 input logic [BIT_W-1:0]  b);
    logic [ROW_AW-1:0] res;
    res = r;
    for (int i = 0; i < ROW_AW; i++)
      if (b == BIT_W'(i)) res[i] = ~r[i];
    return res;
  endfunction

  function automatic logic [NROWS-1:0] row_onehot(input logic [ROW_AW-1:0] r);
    logic [NROWS-1:0] oh;
    oh    = '0;
    oh[r] = 1'b1;
    return oh;
  endfunction

  logic [ROW_AW-1:0] next_row;
  logic [ROW_W-1:0]  acc_data;
  logic [ROW_W-1:0]  merge_data;

  always_comb begin
    next_row   = flip_row(cur_row, step_bit);
    merge_data = acc_active ? acc_data : src_data;
    wr_en      = step_valid && (mode != PC_NORMAL);
    wr_row     = next_row;
    wr_data    = (mode == PC_BOTH_HELD) ? merge_data : src_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_row    <= '0;
      wl_mask    <= row_onehot('0);
      acc_active <= 1'b0;
      acc_data   <= '0;
    end else if (step_valid) begin
      cur_row <= next_row;
      if (mode == PC_BOTH_HELD) begin
        acc_active <= !step_last;
        acc_data   <= merge_data;
        wl_mask    <= step_last ? row_onehot(next_row)
                                : (wl_mask | row_onehot(next_row));
      end else begin
        acc_active <= 1'b0;
        wl_mask    <= row_onehot(next_row);
      end
    end else if (row_set) begin
      cur_row    <= row_set_val;
      wl_mask    <= row_onehot(row_set_val);
      acc_active <= 1'b0;
    end
  end
endmodule

// File: rtl/oam_pf_row_array.sv
module oam_pf_row_array #(
  parameter int ROW_AW = 5,
  parameter int ROW_W  = 64,
  localparam int NROWS = 1 << ROW_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_AW-1:0] wr_row,
  input  logic [ROW_W-1:0]  wr_data,
  input  logic              init_we,
  input  logic [ROW_AW-1:0] init_row,
  input  logic [ROW_W-1:0]  init_data,
  input  logic [ROW_AW-1:0] src_row,
  output logic [ROW_W-1:0]  src_data,
  input  logic [ROW_AW-1:0] rd_row,
  output logic [ROW_W-1:0]  rd_data
);
  logic [ROW_W-1:0] rows [NROWS];

  for (genvar g = 0; g < NROWS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        rows[g] <= '0;
      else if (wr_en && wr_row == ROW_AW'(g))
        rows[g] <= wr_data;
      else if (!wr_en && init_we && init_row == ROW_AW'(g))
        rows[g] <= init_data;
    end
  end

  assign src_data = rows[src_row];
  assign rd_data  = rows[rd_row];
endmodule

// File: rtl/oam_precharge_fault.sv
module oam_precharge_fault
  import oam_pf_pkg::*;
#(
  parameter int ROW_AW = 5,
  parameter int ROW_W  = 64,
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] PAGE = 8'hFE,
  localparam int NROWS = 1 << ROW_AW,
  localparam int BIT_W = (ROW_AW > 1) ? $clog2(ROW_AW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cpu_addr_hi,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              step_valid,
  input  logic [BIT_W-1:0]  step_bit,
  input  logic              step_last,
  input  logic              row_set,
  input  logic [ROW_AW-1:0] row_set_val,
  input  logic              init_we,
  input  logic [ROW_AW-1:0] init_row,
  input  logic [ROW_W-1:0]  init_data,
  input  logic [ROW_AW-1:0] rd_row,
  output logic [ROW_W-1:0]  rd_data,
  output logic [ROW_AW-1:0] cur_row,
  output logic [NROWS-1:0]  wl_mask
);
  // Named internal events, observed by the bound checker.
  logic              page_hit;
  pc_mode_e          mode;
  logic              acc_active;
  logic              wr_en;
  logic [ROW_AW-1:0] wr_row;
  logic [ROW_W-1:0]  wr_data;
  logic [ROW_W-1:0]  src_data;

  oam_pf_precharge #(.PAGE_W(PAGE_W), .PAGE(PAGE)) u_pc (
    .cpu_addr_hi(cpu_addr_hi), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .page_hit(page_hit), .mode(mode)
  );

  oam_pf_wl_tracker #(.ROW_AW(ROW_AW), .ROW_W(ROW_W), .BIT_W(BIT_W)) u_wl (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_bit(step_bit),
    .step_last(step_last), .row_set(row_set), .row_set_val(row_set_val),
    .mode(mode), .src_data(src_data), .cur_row(cur_row), .wl_mask(wl_mask),
    .acc_active(acc_active), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data)
  );

  oam_pf_row_array #(.ROW_AW(ROW_AW), .ROW_W(ROW_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .init_we(init_we), .init_row(init_row), .init_data(init_data),
    .src_row(cur_row), .src_data(src_data), .rd_row(rd_row), .rd_data(rd_data)
  );
endmodule

// File: rtl/oam_precharge_fault_checker.sv
module oam_precharge_fault_checker
  import oam_pf_pkg::*;
#(
  parameter int ROW_AW = 5,
  localparam int NROWS = 1 << ROW_AW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_valid,
  input logic              step_last,
  input logic              cpu_wr,
  input logic              page_hit,
  input pc_mode_e          mode,
  input logic              wr_en,
  input logic              acc_active,
  input logic [ROW_AW-1:0] cur_row,
  input logic [NROWS-1:0]  wl_mask
);
  assert_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !page_hit) |-> !wr_en);

  assert_bl_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && page_hit) |-> wr_en);

  assert_wr_as_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (page_hit && cpu_wr) |-> (mode == PC_BL_HELD));

  assert_one_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> ($countones(cur_row ^ $past(cur_row)) <= 1));

  assert_wl_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && mode == PC_BOTH_HELD && !step_last)
      |=> ($countones(wl_mask) >= $countones($past(wl_mask))));

  assert_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_last) |=> !acc_active);

  assert_single_wl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_active |-> ($countones(wl_mask) == 1 && wl_mask[cur_row]));
endmodule

bind oam_precharge_fault oam_precharge_fault_checker #(.ROW_AW(ROW_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_last(step_last),
  .cpu_wr(cpu_wr), .page_hit(page_hit), .mode(mode), .wr_en(wr_en),
  .acc_active(acc_active), .cur_row(cur_row), .wl_mask(wl_mask)
);

// File: tb/oam_precharge_fault_bench.sv
module oam_precharge_fault_bench;
  localparam int AW = 5;
  localparam int W  = 64;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cpu_addr_hi = 8'h00;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic step_valid = 1'b0, step_last = 1'b0;
  logic [2:0] step_bit = '0;
  logic row_set = 1'b0;
  logic [AW-1:0] row_set_val = '0;
  logic init_we = 1'b0;
  logic [AW-1:0] init_row = '0;
  logic [W-1:0] init_data = '0;
  logic [AW-1:0] rd_row = '0;
  logic [W-1:0] rd_data;
  logic [AW-1:0] cur_row;
  logic [NR-1:0] wl_mask;

  always #10 clk = ~clk;  // 50 MHz

  oam_precharge_fault u_oam_precharge_fault (
    .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .step_valid(step_valid), .step_bit(step_bit),
    .step_last(step_last), .row_set(row_set), .row_set_val(row_set_val),
    .init_we(init_we), .init_row(init_row), .init_data(init_data),
    .rd_row(rd_row), .rd_data(rd_data), .cur_row(cur_row), .wl_mask(wl_mask)
  );

  typedef struct { string tag; int row; logic [W-1:0] data; } exp_t;
  exp_t exp_q[$];
  bit   mon_req = 1'b0;
  int   n_checks = 0, n_errors = 0;

  // Reference state, built from the requirements.
  logic [W-1:0]  ref_mem [NR];
  int            ref_row;
  logic [NR-1:0] ref_mask;
  bit            ref_acc;
  logic [W-1:0]  ref_accd;

  function automatic logic [W-1:0] pat(input int r, input int salt);
    return {8{8'(r * 37 + 11 + salt)}} ^ {32'(r), 32'hC0DE_0000 | 32'(salt)};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected rows and compares them with the read port.
  initial forever begin
    wait (mon_req);
    while (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      rd_row = AW'(it.row);
      #1;
      check($sformatf("%s row %0d", it.tag, it.row), rd_data, it.data);
    end
    mon_req = 1'b0;
  end

  task automatic scoreboard_all(input string tag);
    for (int r = 0; r < NR; r++) begin
      exp_t it;
      it.tag = tag; it.row = r; it.data = ref_mem[r];
      exp_q.push_back(it);
    end
    mon_req = 1'b1;
    wait (!mon_req);
  endtask

  task automatic preload(input int salt);
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      init_we = 1'b1; init_row = AW'(r); init_data = pat(r, salt);
      ref_mem[r] = pat(r, salt);
    end
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic place(input int r);
    @(negedge clk);
    row_set = 1'b1; row_set_val = AW'(r);
    @(negedge clk);
    row_set = 1'b0;
    ref_row = r; ref_mask = '0; ref_mask[r] = 1'b1; ref_acc = 1'b0;
    check("R10 row_set", W'(cur_row), W'(r));
  endtask

  // mode: 0 off-page read, 1 bare page address, 2 page write, 3 page read
  task automatic drive_mode(input int m);
    cpu_addr_hi = (m == 0) ? 8'h80 : 8'hFE;
    cpu_rd      = (m == 0 || m == 3);
    cpu_wr      = (m == 2);
  endtask

  task automatic run_trans(input string tag, input int n, input int bits[5], input int modes[5]);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int nrow;
      logic [W-1:0] d;
      bit last;
      last = (i == n - 1);
      drive_mode(modes[i]);
      step_valid = 1'b1; step_bit = 3'(bits[i]); step_last = last;
      nrow = ref_row ^ (1 << bits[i]);
      if (modes[i] == 3) begin
        d = ref_acc ? ref_accd : ref_mem[ref_row];
        ref_mem[nrow] = d; ref_accd = d; ref_acc = !last;
        if (last) begin ref_mask = '0; ref_mask[nrow] = 1'b1; end
        else ref_mask[nrow] = 1'b1;
      end else begin
        if (modes[i] != 0) ref_mem[nrow] = ref_mem[ref_row];
        ref_acc = 1'b0; ref_mask = '0; ref_mask[nrow] = 1'b1;
      end
      ref_row = nrow;
      @(negedge clk);
      check({tag, " R3 cur_row"}, W'(cur_row), W'(ref_row));
      check({tag, " R11 wl_mask"}, W'(wl_mask), W'(ref_mask));
    end
    step_valid = 1'b0; step_last = 1'b0;
    drive_mode(1); cpu_addr_hi = 8'h00; cpu_rd = 1'b0;
    scoreboard_all(tag);
  endtask

  initial begin
    #(200000 * 20);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) ref_mem[r] = '0;
    ref_row = 0; ref_mask = '0; ref_mask[0] = 1'b1; ref_acc = 1'b0; ref_accd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset cur_row", W'(cur_row), '0);
    check("R1 reset wl_mask", W'(wl_mask), W'(1));
    scoreboard_all("R1 reset array");

    preload(0);
    scoreboard_all("R10 preload");

    // R4 / R2: off-page read, selection moves, data does not
    run_trans("R4 R2 off-page", 3, '{0, 1, 2, 0, 0}, '{0, 0, 0, 0, 0});

    // R8: single-flip read, 8 copied over 0
    place(8);
    run_trans("R8 single flip", 1, '{3, 0, 0, 0, 0}, '{3, 0, 0, 0, 0});

    // R7: same start, two flip orders hit different rows
    preload(1); place(7);
    run_trans("R7 order 0-1-2", 3, '{0, 1, 2, 0, 0}, '{3, 3, 3, 0, 0});
    preload(1); place(7);
    run_trans("R7 order 2-1-0", 3, '{2, 1, 0, 0, 0}, '{3, 3, 3, 0, 0});

    // R5 and R6: bare address and write give the same array
    preload(2); place(1);
    run_trans("R5 bare addr", 3, '{1, 2, 4, 0, 0}, '{1, 1, 1, 0, 0});
    preload(2); place(1);
    run_trans("R6 write", 3, '{1, 2, 4, 0, 0}, '{2, 2, 2, 0, 0});

    // R5 / R7 mixed: carry uses current row, merge uses captured data
    preload(3); place(12);
    run_trans("R5 R7 mixed", 4, '{0, 1, 4, 2, 0}, '{0, 1, 3, 3, 0});

    // R9: back-to-back read transitions restart from their own start row
    preload(4); place(20);
    run_trans("R9 first", 2, '{0, 3, 0, 0, 0}, '{3, 3, 0, 0, 0});
    run_trans("R9 second", 2, '{1, 2, 0, 0, 0}, '{3, 3, 0, 0, 0});

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule